// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block multiplies two operand words and folds the double-width product into a 64-bit accumulator. The accumulator is held as two word registers: HI holds the upper half and LO holds the lower half. A 4-bit operation code selects one of four arithmetic functions:

- plain multiply
- negated multiply
- multiply-add
- multiply-subtract

Each function has signed and unsigned operand handling. The code also chooses whether the new LO or the new HI word is returned on the result port. Every operation rewrites HI and LO from the 64-bit result.

Operations enter on a valid/ready stream port. The unit holds at most one operation at a time. `in_ready` falls on the edge that accepts an operation and rises again in the cycle the result appears. A valid presented while `in_ready` is low is not taken. The producer may hold it, but the unit never latches its fields. The result side has no back-pressure. `out_valid` is a single-cycle strobe a fixed number of cycles after acceptance, and `out_word` holds its value until the next completion. HI and LO are visible at all times on their own ports.

Top module: `hilo_mac_unit`

## Requirements
- R1: After reset, HI and LO read zero, `out_valid` is low, `out_word` is zero and `in_ready` is high.
- R2: The operation code is decoded as follows. Bit 3 set means unsigned operands. Bit 2 set means the HI word is returned. Bits 1:0 pick the function: 00 multiply, 01 negated multiply, 10 multiply-add, 11 multiply-subtract.
- R3: Signed operations sign-extend both operands to 64 bits before multiplying. Unsigned operations zero-extend them.
- R4: Multiply-add writes (HI:LO + product) mod 2^64 into the accumulator, with no overflow indication.
- R5: Multiply-subtract writes (HI:LO − product) mod 2^64 into the accumulator.
- R6: Plain multiply loads the product, and negated multiply loads (0 − product) mod 2^64. Neither depends on the previous HI:LO.
- R7: Result bits 31:0 go to LO and bits 63:32 go to HI, for every function.
- R8: `out_word` carries the new LO when bit 2 is clear and the new HI when bit 2 is set.
- R9: `out_valid` is high for exactly one cycle, MUL_STAGES+1 clock edges after the accepting edge (the accepting edge counts as the first).
- R10: `in_ready` is low from the accepting edge until the result cycle. A valid offered while `in_ready` is low changes neither HI, LO nor the result.
- R11: HI and LO change only on the edge that produces a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 4 | Operation code (see R2) |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand |
| out_valid | output | 1 | One-cycle completion strobe |
| out_word | output | DATA_W | Returned HI or LO word |
| hi_q | output | DATA_W | Accumulator upper half |
| lo_q | output | DATA_W | Accumulator lower half |

## Verification
The bench builds the unit with DATA_W=32 and MUL_STAGES=2, which gives a three-edge latency. This latency leaves two busy cycles in which rejected offers can be placed. With full 32-bit operands, products reach the carry and borrow across the LO/HI boundary. Cases such as all-ones times all-ones show signed and unsigned products differing only in HI. A held-high valid exercises acceptance in the same cycle a result retires.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;

  typedef enum logic [1:0] {
    FN_MUL  = 2'b00,
    FN_NMUL = 2'b01,
    FN_MADD = 2'b10,
    FN_MSUB = 2'b11
  } mac_fn_e;

  // bit 3: unsigned, bit 2: return HI, bits 1:0: function
  typedef struct packed {
    logic    is_unsigned;
    logic    ret_hi;
    mac_fn_e fn;
  } mac_op_t;

  function automatic mac_op_t decode_op(input logic [3:0] code);
    return mac_op_t'(code);
  endfunction

endpackage

// File: rtl/hilo_ctrl.sv
module hilo_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic retire,
  output logic in_ready,
  output logic accept
);
  logic busy_q;

  assign in_ready = !busy_q;
  assign accept   = in_valid && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (accept)  busy_q <= 1'b1;
    else if (retire)  busy_q <= 1'b0;
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready); // R10
  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !accept) |=> in_ready); // R10

endmodule

// File: rtl/hilo_mul_pipe.sv
module hilo_mul_pipe
  import hilo_mac_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MUL_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              prod_valid,
  output logic [2*DATA_W-1:0] prod,
  output mac_op_t           prod_op
);
  localparam int PW = 2 * DATA_W;

  logic signed [DATA_W:0] ea_q, eb_q;
  mac_op_t                op_q;
  logic [MUL_STAGES-1:0]  vld_q;
  logic [PW-1:0]          p0;

  // stage 0: capture extended operands; operands stay put until the next accept
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_q  <= '0;
      eb_q  <= '0;
      op_q  <= mac_op_t'('0);
      vld_q <= '0;
    end else begin
      vld_q <= (vld_q << 1) | MUL_STAGES'(accept);
      if (accept) begin
        op_q <= decode_op(op_code);
        ea_q <= decode_op(op_code).is_unsigned ? {1'b0, a} : {a[DATA_W-1], a};
        eb_q <= decode_op(op_code).is_unsigned ? {1'b0, b} : {b[DATA_W-1], b};
      end
    end
  end

  assign p0 = PW'(ea_q) * PW'(eb_q);

  generate
    if (MUL_STAGES == 1) begin : g_flat
      assign prod = p0;
    end else begin : g_deep
      logic [PW-1:0] pr_q [MUL_STAGES-1];
      always_ff @(posedge clk) begin
        pr_q[0] <= p0;
        for (int i = 1; i < MUL_STAGES - 1; i++) pr_q[i] <= pr_q[i-1];
      end
      assign prod = pr_q[MUL_STAGES-2];
    end
  endgenerate

  assign prod_valid = vld_q[MUL_STAGES-1];
  assign prod_op    = op_q;

  AST_PIPE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vld_q)); // R10
  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(op_q)); // R10

endmodule

// File: rtl/hilo_accum.sv
module hilo_accum
  import hilo_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [2*DATA_W-1:0] prod,
  input  mac_op_t             op,
  output logic [DATA_W-1:0]   hi_q,
  output logic [DATA_W-1:0]   lo_q,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_word
);
  localparam int PW = 2 * DATA_W;

  logic [PW-1:0] acc, res;

  assign acc = {hi_q, lo_q};

  always_comb begin
    unique case (op.fn)
      FN_MUL:  res = prod;
      FN_NMUL: res = PW'(0) - prod;
      FN_MADD: res = acc + prod;
      FN_MSUB: res = acc - prod;
      default: res = prod;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q      <= '0;
      lo_q      <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        hi_q     <= res[PW-1:DATA_W];
        lo_q     <= res[DATA_W-1:0];
        out_word <= op.ret_hi ? res[PW-1:DATA_W] : res[DATA_W-1:0];
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R9
  AST_HILO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable({hi_q, lo_q})); // R11
  AST_WORD_FROM_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word == hi_q || out_word == lo_q)); // R8

endmodule

// File: rtl/hilo_mac_unit.sv
module hilo_mac_unit
  import hilo_mac_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MUL_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_word,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] lo_q
);
  localparam int LATENCY = MUL_STAGES + 1;

  logic                accept, fire;
  logic [2*DATA_W-1:0] prod;
  mac_op_t             prod_op;

  hilo_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .retire   (fire),
    .in_ready (in_ready),
    .accept   (accept)
  );

  hilo_mul_pipe #(.DATA_W(DATA_W), .MUL_STAGES(MUL_STAGES)) u_mul (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .op_code    (in_op),
    .a          (in_a),
    .b          (in_b),
    .prod_valid (fire),
    .prod       (prod),
    .prod_op    (prod_op)
  );

  hilo_accum #(.DATA_W(DATA_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .prod      (prod),
    .op        (prod_op),
    .hi_q      (hi_q),
    .lo_q      (lo_q),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

  initial begin
    AST_LATENCY_MIN: assert (LATENCY >= 2); // R9
  end

endmodule

// File: tb/hilo_mac_unit_bench.sv
module hilo_mac_unit_bench;
  localparam int DW  = 32;
  localparam int STG = 2;
  localparam int LAT = STG + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [3:0] in_op = '0;
  logic [DW-1:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_word, hi_q, lo_q;

  always #5 clk = ~clk;

  hilo_mac_unit #(.DATA_W(DW), .MUL_STAGES(STG)) u_hilo_mac_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_word(out_word), .hi_q(hi_q), .lo_q(lo_q)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";

  // reference state
  logic [63:0] m_acc = '0;
  logic [31:0] m_word = '0;
  logic m_valid = 1'b0, m_busy = 1'b0;
  int m_cnt = 0;
  logic [3:0] p_op;
  logic [31:0] p_a, p_b;

  function automatic logic [63:0] ref_result(logic [63:0] acc, logic [3:0] op,
                                             logic [31:0] a, logic [31:0] b);
    logic [63:0] ea, eb, pr;
    ea = op[3] ? {32'b0, a} : {{32{a[31]}}, a};        // R3
    eb = op[3] ? {32'b0, b} : {{32{b[31]}}, b};
    pr = ea * eb;
    case (op[1:0])
      2'b00: return pr;                                // R6
      2'b01: return 64'd0 - pr;                        // R6
      2'b10: return acc + pr;                          // R4
      default: return acc - pr;                        // R5
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check({cur_tag, "/R7 hi"}, 64'(hi_q), 64'(m_acc[63:32]));
    check({cur_tag, "/R7 lo"}, 64'(lo_q), 64'(m_acc[31:0]));
    check("R9 out_valid", 64'(out_valid), 64'(m_valid));
    check("R8 out_word", 64'(out_word), 64'(m_word));
    check("R10 in_ready", 64'(in_ready), 64'(!m_busy));
  endtask

  task automatic model_step(logic v, logic [3:0] op, logic [31:0] a, logic [31:0] b);
    logic rdy;
    rdy = !m_busy;
    m_valid = 1'b0;
    if (m_busy) begin
      if (m_cnt == 1) begin
        m_acc   = ref_result(m_acc, p_op, p_a, p_b);
        m_word  = p_op[2] ? m_acc[63:32] : m_acc[31:0];  // R2 bit 2
        m_valid = 1'b1;
        m_busy  = 1'b0;
      end else m_cnt--;
    end
    if (v && rdy) begin
      p_op = op; p_a = a; p_b = b;
      m_busy = 1'b1;
      m_cnt = LAT - 1;
    end
  endtask

  task automatic cycle(logic v, logic [3:0] op, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    compare_all();
    in_valid = v; in_op = op; in_a = a; in_b = b;
    model_step(v, op, a, b);
  endtask

  task automatic run_op(string tag, logic [3:0] op, logic [31:0] a, logic [31:0] b);
    cur_tag = tag;
    cycle(1'b1, op, a, b);
    for (int i = 0; i < LAT; i++) cycle(1'b0, 4'h0, 32'h0, 32'h0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cur_tag = "R1";
    cycle(1'b0, 4'h0, 32'h0, 32'h0);                   // R1 reset state
    run_op("R3", 4'b0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // signed -1*-1
    run_op("R3", 4'b1000, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // unsigned
    run_op("R2", 4'b1100, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // HI return
    run_op("R4", 4'b1010, 32'h8000_0000, 32'h0000_0004); // carry into HI
    run_op("R4", 4'b0110, 32'hFFFF_FFFE, 32'h0000_0003);
    run_op("R5", 4'b1011, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // borrow
    run_op("R5", 4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
    run_op("R6", 4'b0001, 32'h0000_1234, 32'hFFFF_FFFE);
    run_op("R6", 4'b1101, 32'h0000_0001, 32'h0000_0001);
    run_op("R6", 4'b0100, 32'h8000_0000, 32'h8000_0000);
    // offers while busy must be dropped
    cur_tag = "R10";
    cycle(1'b1, 4'b1010, 32'h0000_0010, 32'h0000_0010);
    cycle(1'b1, 4'b0000, 32'hDEAD_BEEF, 32'h1234_5678);
    cycle(1'b1, 4'b0001, 32'hCAFE_F00D, 32'h0BAD_0BAD);
    for (int i = 0; i < LAT; i++) cycle(1'b0, 4'h0, 32'h0, 32'h0);
    // valid held high across completions
    cur_tag = "R9";
    for (int i = 0; i < 12; i++)
      cycle(1'b1, 4'(i), 32'h1357_9BDF + 32'(i), 32'hFEDC_BA98 - 32'(i * 7));
    // idle stretch: accumulator must not move
    cur_tag = "R11";
    for (int i = 0; i < 6; i++) cycle(1'b0, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    cur_tag = "R2";
    for (int i = 0; i < 300; i++)
      cycle(($urandom % 3) != 0, 4'($urandom), $urandom, $urandom);
    for (int i = 0; i < LAT + 1; i++) cycle(1'b0, 4'h0, 32'h0, 32'h0);
    finish_run();
  end

endmodule